// File: doc/BRIEF.md
# Multi-Format Serial Audio Transmitter

This block is the transmit side of a slave-mode serial audio port. It sends three lanes of stereo audio to the outside world. Each lane takes a parallel 24-bit left sample and a 24-bit right sample. The bit clock and the frame clock both come from outside the block. A core clock that runs much faster than the bit clock oversamples both of them. Every output bit is launched on a detected falling edge of the bit clock, so a receiver can latch it on the next rising edge.

Two independent 2-bit controls set the line format and the word length.

- **Format select:** the frame can be justified to the start of each half (MSB justified), delayed by one bit clock (I2S), or justified to the end of each half (LSB justified).
- **Length select:** the sample is cut down to 16, 18, 20 or 24 bits by dropping its least significant bits.

Other controls:

- **Power-down input:** forces every lane low and restarts the framing logic.
- **Reduced-channel input:** silences the last lane.

A small state machine sequences start-up. It has three states:

- `ST_PDOWN`: power-down.
- `ST_WAIT_LEFT`: waiting for the first left half.
- `ST_STREAM`: streaming.

Its transitions are:

- `ST_PDOWN`→`ST_WAIT_LEFT` on release of power-down.
- `ST_WAIT_LEFT`→`ST_STREAM` at the first frame-clock edge that starts a left half.
- Any state→`ST_PDOWN` while power-down is high.

Top module: `audtx_serializer`

## Requirements
- R1: While `pd_i` is high, every bit of `sdo_o` is low. Power-down also returns the controller to `ST_PDOWN`, which clears all framing history.
- R2: The format code `fmt_i` is encoded as 00 = LSB justified, 01 = reserved, 10 = MSB justified, 11 = I2S. With the reserved code, every lane sends only low bits.
- R3: A lane output changes only as a result of a bit-clock falling edge. It updates within two core-clock cycles of that edge and then holds steady until the next falling edge.
- R4: The length code `len_i` is encoded as 00 = 16, 01 = 18, 10 = 20, 11 = 24 bits. The transmitted word is the top N bits of the 24-bit sample, sent MSB first. Every bit position outside the word is low.
- R5: In MSB-justified format, the left half is the half where the frame clock is high. The word's MSB goes out on the first bit clock of each half.
- R6: In I2S format, the left half is the half where the frame clock is low. The MSB goes out on the second bit clock of each half, one bit after the frame-clock edge.
- R7: In LSB-justified format (left half = frame clock high), the word's LSB goes out on the final bit clock of each half. The half length used is the bit-clock count of the preceding complete half. Until one full half has been counted since power-down release, the output is low.
- R8: When `quad_i` is high, the last lane (`sdo_o[2]`) sends only low bits from the next falling edge on. The other lanes are unaffected.
- R9: Each lane captures its left and right samples at the falling edge that starts a left half. The right half sends the right sample captured at that edge, even if `right_i` changes during the frame.
- R10: After power-down release, all outputs stay low in `ST_WAIT_LEFT` until the first left-half start, which moves the controller to `ST_STREAM`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, oversamples the serial clocks |
| rst_n | input | 1 | Active-low asynchronous reset |
| pd_i | input | 1 | Power-down: forces outputs low and restarts framing |
| quad_i | input | 1 | Reduced-channel mode: silences the last lane |
| fmt_i | input | 2 | Line format code (see R2) |
| len_i | input | 2 | Word length code (see R4) |
| bclk_i | input | 1 | External bit clock |
| lrclk_i | input | 1 | External frame clock |
| left_i | input | 72 | Left samples, lane k at bits [24k+23:24k] |
| right_i | input | 72 | Right samples, lane k at bits [24k+23:24k] |
| sdo_o | output | 3 | Serial data, one bit per lane |

## Verification
A wrong half-frame position or a missed frame-clock edge shows up on the lanes as a bit in the wrong slot. That error is visible at the very next bit-clock period, because every launched bit is compared with a model held in the bench. A stale half-length value in LSB-justified mode shifts the whole word and shows within the first half after the error. Wrong sample capture only shows in the right half once the inputs have changed mid-frame, so the bench changes them there in every frame. A launch that comes early or late is caught by comparing the output both just after each falling edge and again later in the same bit.

// File: rtl/audtx_pkg.sv
package audtx_pkg;

    typedef enum logic [1:0] {
        FMT_LSB = 2'b00,
        FMT_RSV = 2'b01,
        FMT_MSB = 2'b10,
        FMT_I2S = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        ST_PDOWN     = 2'b00,
        ST_WAIT_LEFT = 2'b01,
        ST_STREAM    = 2'b10
    } state_e;

    // word length for the length code (R4)
    function automatic int word_bits(input logic [1:0] code);
        case (code)
            2'b00:   return 16;
            2'b01:   return 18;
            2'b10:   return 20;
            default: return 24;
        endcase
    endfunction

endpackage

// File: rtl/audtx_edge.sv
module audtx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_i,
    input  logic lrclk_i,
    output logic fall_o,
    output logic lr_o
);
    logic bclk_s1, bclk_s2, lr_s1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_s1 <= 1'b0;
            bclk_s2 <= 1'b0;
            lr_s1   <= 1'b0;
        end else begin
            bclk_s1 <= bclk_i;
            bclk_s2 <= bclk_s1;
            lr_s1   <= lrclk_i;
        end
    end

    assign fall_o = bclk_s2 & ~bclk_s1;
    assign lr_o   = lr_s1;
endmodule

// File: rtl/audtx_frame.sv
module audtx_frame
    import audtx_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pd_i,
    input  logic [1:0]       fmt_i,
    input  logic             fall_i,
    input  logic             lr_i,
    output logic             emit_o,
    output logic             start_left_o,
    output logic             left_now_o,
    output logic [CNT_W-1:0] pos_now_o,
    output logic [CNT_W:0]   len_now_o,
    output logic             len_ok_o
);
    localparam logic [CNT_W-1:0] POS_MAX = '1;

    state_e           state_q, state_d;
    logic [CNT_W-1:0] pos_q;
    logic [CNT_W:0]   len_q;
    logic             seen_q, len_ok_q, lr_last_q;
    logic             changed, left_lvl;

    assign left_lvl = (fmt_e'(fmt_i) == FMT_I2S) ? 1'b0 : 1'b1;
    assign changed  = (lr_i != lr_last_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PDOWN;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        start_left_o = fall_i && changed && (lr_i == left_lvl);
        left_now_o   = (lr_i == left_lvl);
        pos_now_o    = changed ? '0 : ((pos_q == POS_MAX) ? pos_q : pos_q + 1'b1);
        len_now_o    = (changed && seen_q) ? ({1'b0, pos_q} + 1'b1) : len_q;
        len_ok_o     = len_ok_q | (changed & seen_q);
        emit_o       = 1'b0;
        state_d      = state_q;
        unique case (state_q)
            ST_PDOWN: begin
                if (!pd_i) state_d = ST_WAIT_LEFT;
            end
            ST_WAIT_LEFT: begin
                if (start_left_o) begin
                    state_d = ST_STREAM;
                    emit_o  = 1'b1;
                end
            end
            ST_STREAM: begin
                emit_o = fall_i;
            end
            default: state_d = ST_PDOWN;
        endcase
        if (pd_i) begin
            state_d = ST_PDOWN;
            emit_o  = 1'b0;
        end
    end

    // half-frame position and length history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q     <= '0;
            len_q     <= '0;
            seen_q    <= 1'b0;
            len_ok_q  <= 1'b0;
            lr_last_q <= 1'b0;
        end else if (pd_i || state_q == ST_PDOWN) begin
            pos_q     <= '0;
            len_q     <= '0;
            seen_q    <= 1'b0;
            len_ok_q  <= 1'b0;
            lr_last_q <= lr_i;
        end else if (fall_i) begin
            pos_q     <= pos_now_o;
            lr_last_q <= lr_i;
            if (changed) begin
                seen_q <= 1'b1;
                if (seen_q) begin
                    len_q    <= len_now_o;
                    len_ok_q <= 1'b1;
                end
            end
        end
    end

    // R10: streaming is only reached through the wait state
    a_r10_no_skip_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STREAM) |-> ($past(state_q) != ST_PDOWN));

    // R1: power-down always lands in the power-down state
    a_r1_pd_state: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pd_i) |-> (state_q == ST_PDOWN));
endmodule

// File: rtl/audtx_lane.sv
module audtx_lane
    import audtx_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int CNT_W    = 7,
    parameter bit IS_LAST  = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pd_i,
    input  logic                quad_i,
    input  logic [1:0]          fmt_i,
    input  logic [1:0]          len_code_i,
    input  logic                fall_i,
    input  logic                emit_i,
    input  logic                start_left_i,
    input  logic                left_now_i,
    input  logic [CNT_W-1:0]    pos_i,
    input  logic [CNT_W:0]      len_i,
    input  logic                len_ok_i,
    input  logic [SAMPLE_W-1:0] left_i,
    input  logic [SAMPLE_W-1:0] right_i,
    output logic                bit_o
);
    localparam int IW = $clog2(SAMPLE_W);

    logic [SAMPLE_W-1:0] hold_l, hold_r, word;
    logic [IW-1:0]       sel;
    logic                bit_d, bit_q, hit;
    int                  w, p, h, idx;

    always_comb begin
        word = left_now_i ? (start_left_i ? left_i : hold_l) : hold_r;
        w    = word_bits(len_code_i);
        p    = int'(pos_i);
        h    = int'(len_i);
        idx  = 0;
        hit  = 1'b0;
        case (fmt_e'(fmt_i))
            FMT_MSB: if (p < w) begin
                hit = 1'b1;
                idx = SAMPLE_W - 1 - p;
            end
            FMT_I2S: if (p >= 1 && p <= w) begin
                hit = 1'b1;
                idx = SAMPLE_W - p;
            end
            FMT_LSB: if (len_ok_i && p < h && (h - 1 - p) < w) begin
                hit = 1'b1;
                idx = SAMPLE_W - w + h - 1 - p;
            end
            default: hit = 1'b0;
        endcase
        sel   = IW'(idx);
        bit_d = hit & word[sel];
        if (IS_LAST && quad_i) bit_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q  <= 1'b0;
            hold_l <= '0;
            hold_r <= '0;
        end else begin
            if (start_left_i) begin
                hold_l <= left_i;
                hold_r <= right_i;
            end
            if (pd_i)        bit_q <= 1'b0;
            else if (fall_i) bit_q <= emit_i ? bit_d : 1'b0;
        end
    end

    assign bit_o = bit_q;

    // R3: the lane bit moves only after a detected falling edge
    a_r3_launch_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(fall_i) && !$past(pd_i)) |-> $stable(bit_q));

    // R2: reserved format launches only zeros
    a_r2_reserved_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fall_i) && ($past(fmt_i) == FMT_RSV)) |-> !bit_q);

    // R1: lane register cleared under power-down
    a_r1_pd_low: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pd_i) |-> !bit_q);

    generate
        if (IS_LAST) begin : g_quad_chk
            // R8: reduced-channel mode silences this lane
            a_r8_quad_low: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(fall_i) && $past(quad_i)) |-> !bit_q);
        end
    endgenerate
endmodule

// File: rtl/audtx_serializer.sv
module audtx_serializer
    import audtx_pkg::*;
#(
    parameter int LANES    = 3,
    parameter int SAMPLE_W = 24,
    parameter int CNT_W    = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      pd_i,
    input  logic                      quad_i,
    input  logic [1:0]                fmt_i,
    input  logic [1:0]                len_i,
    input  logic                      bclk_i,
    input  logic                      lrclk_i,
    input  logic [LANES*SAMPLE_W-1:0] left_i,
    input  logic [LANES*SAMPLE_W-1:0] right_i,
    output logic [LANES-1:0]          sdo_o
);
    logic             fall, lr, emit, start_left, left_now, len_ok;
    logic [CNT_W-1:0] pos_now;
    logic [CNT_W:0]   len_now;
    logic [LANES-1:0] lane_bits;

    audtx_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .bclk_i  (bclk_i),
        .lrclk_i (lrclk_i),
        .fall_o  (fall),
        .lr_o    (lr)
    );

    audtx_frame #(.CNT_W(CNT_W)) u_frame (
        .clk          (clk),
        .rst_n        (rst_n),
        .pd_i         (pd_i),
        .fmt_i        (fmt_i),
        .fall_i       (fall),
        .lr_i         (lr),
        .emit_o       (emit),
        .start_left_o (start_left),
        .left_now_o   (left_now),
        .pos_now_o    (pos_now),
        .len_now_o    (len_now),
        .len_ok_o     (len_ok)
    );

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            audtx_lane #(
                .SAMPLE_W (SAMPLE_W),
                .CNT_W    (CNT_W),
                .IS_LAST  (k == LANES - 1)
            ) u_lane (
                .clk          (clk),
                .rst_n        (rst_n),
                .pd_i         (pd_i),
                .quad_i       (quad_i),
                .fmt_i        (fmt_i),
                .len_code_i   (len_i),
                .fall_i       (fall),
                .emit_i       (emit),
                .start_left_i (start_left),
                .left_now_i   (left_now),
                .pos_i        (pos_now),
                .len_i        (len_now),
                .len_ok_i     (len_ok),
                .left_i       (left_i[k*SAMPLE_W +: SAMPLE_W]),
                .right_i      (right_i[k*SAMPLE_W +: SAMPLE_W]),
                .bit_o        (lane_bits[k])
            );
        end
    endgenerate

    assign sdo_o = pd_i ? '0 : lane_bits;
endmodule

// File: tb/sim_audtx_serializer.sv
`timescale 1ns/1ps
module sim_audtx_serializer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pd = 1'b1, quad = 1'b0, bclk = 1'b1, lrclk = 1'b0;
    logic [1:0]  fmt = 2'b10, len = 2'b11;
    logic [71:0] lbus = '0, rbus = '0;
    logic [2:0]  sdo;

    int checks = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;  // 125 MHz

    audtx_serializer u0 (
        .clk(clk), .rst_n(rst_n), .pd_i(pd), .quad_i(quad),
        .fmt_i(fmt), .len_i(len), .bclk_i(bclk), .lrclk_i(lrclk),
        .left_i(lbus), .right_i(rbus), .sdo_o(sdo)
    );

    // behavioural reference state
    int          m_pos, m_len;
    bit          m_seen, m_ok, m_started, m_last, m_leftnow;
    logic [23:0] cap_l [3], cap_r [3];
    logic [2:0]  m_exp, m_prev;
    int unsigned seed = 32'h1234_5678;

    function automatic logic [23:0] next_rand();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed[31:8];
    endfunction

    task automatic new_samples(bit left_too);
        for (int k = 0; k < 3; k++) begin
            if (left_too) lbus[k*24 +: 24] = next_rand();
            rbus[k*24 +: 24] = next_rand();
        end
    endtask

    function automatic bit left_level();
        return (fmt == 2'b11) ? 1'b0 : 1'b1;
    endfunction

    function automatic int wlen();
        case (len)
            2'b00: return 16;
            2'b01: return 18;
            2'b10: return 20;
            default: return 24;
        endcase
    endfunction

    task automatic check(logic [2:0] got, logic [2:0] exp, string tag);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s at %0t: sdo=%b expected %b", tag, $time, got, exp);
        end
    endtask

    task automatic model_reset();
        m_pos = 0; m_len = 0; m_seen = 0; m_ok = 0; m_started = 0;
        m_last = lrclk; m_exp = '0; m_prev = '0;
    endtask

    task automatic model_fall(bit lv);
        bit chg;
        logic [23:0] wd;
        int p, w, h;
        chg = (lv != m_last);
        m_last = lv;
        if (chg) begin
            if (m_seen) begin m_len = m_pos + 1; m_ok = 1; end
            m_seen = 1;
            m_pos = 0;
        end else if (m_pos < 127) m_pos++;
        m_leftnow = (lv == left_level());
        if (chg && m_leftnow) begin
            m_started = 1;
            for (int k = 0; k < 3; k++) begin
                cap_l[k] = lbus[k*24 +: 24];
                cap_r[k] = rbus[k*24 +: 24];
            end
        end
        m_prev = m_exp;
        p = m_pos; w = wlen(); h = m_len;
        for (int k = 0; k < 3; k++) begin
            wd = m_leftnow ? cap_l[k] : cap_r[k];
            m_exp[k] = 1'b0;
            if (m_started && !(k == 2 && quad)) begin
                case (fmt)
                    2'b10: if (p < w) m_exp[k] = wd[23 - p];
                    2'b11: if (p >= 1 && p <= w) m_exp[k] = wd[24 - p];
                    2'b00: if (m_ok && p < h && (h - 1 - p) < w) m_exp[k] = wd[24 - w + h - 1 - p];
                    default: m_exp[k] = 1'b0;
                endcase
            end
        end
    endtask

    // one bit period: 4 core clocks low, 4 high
    task automatic send_bit(bit lv, string tag);
        @(negedge clk);
        bclk = 1'b0; lrclk = lv;
        model_fall(lv);
        @(negedge clk);
        check(sdo, m_prev, "R3 (before launch)");
        repeat (2) @(negedge clk);
        check(sdo, m_exp, tag);
        @(negedge clk);
        bclk = 1'b1;
        repeat (3) @(negedge clk);
        check(sdo, m_exp, "R3 (held)");
    endtask

    task automatic run_config(logic [1:0] f, logic [1:0] l, bit q, int half, int frames, string tag);
        bit ll;
        pd = 1'b1;
        @(negedge clk);
        fmt = f; len = l; quad = q; bclk = 1'b1;
        ll = left_level();
        lrclk = ~ll;
        new_samples(1);
        repeat (4) @(negedge clk);
        check(sdo, 3'b000, "R1 power-down");
        pd = 1'b0;
        model_reset();
        repeat (4) @(negedge clk);
        // lead-in bits before the first left half: R10
        send_bit(~ll, "R10");
        send_bit(~ll, "R10");
        for (int fr = 0; fr < frames; fr++) begin
            for (int b = 0; b < half; b++) send_bit(ll, tag);
            for (int b = 0; b < half; b++) begin
                if (b == half / 2) new_samples(1);  // changed mid right half
                send_bit(~ll, (b >= half / 2) ? "R9" : tag);
            end
        end
    endtask

    initial begin
        model_reset();
        repeat (5) @(negedge clk);
        check(sdo, 3'b000, "R1 reset");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(sdo, 3'b000, "R1 after reset");

        run_config(2'b10, 2'b11, 0, 32, 2, "R5");
        run_config(2'b10, 2'b01, 0, 32, 2, "R4");
        run_config(2'b10, 2'b00, 0, 24, 2, "R4");
        run_config(2'b11, 2'b00, 0, 32, 2, "R6");
        run_config(2'b11, 2'b11, 0, 32, 2, "R6");
        run_config(2'b00, 2'b00, 0, 16, 3, "R7");
        run_config(2'b00, 2'b01, 0, 18, 3, "R7");
        run_config(2'b00, 2'b10, 0, 20, 3, "R7");
        run_config(2'b00, 2'b11, 0, 24, 3, "R7");
        run_config(2'b00, 2'b10, 0, 32, 3, "R7");
        run_config(2'b10, 2'b11, 1, 32, 2, "R8");
        run_config(2'b11, 2'b10, 1, 32, 2, "R8");
        run_config(2'b01, 2'b11, 0, 32, 2, "R2");

        // R1: power-down in the middle of a stream
        run_config(2'b10, 2'b11, 0, 32, 1, "R5");
        for (int b = 0; b < 5; b++) send_bit(1'b1, "R5");
        pd = 1'b1;
        @(negedge clk);
        check(sdo, 3'b000, "R1 mid-stream");
        repeat (8) @(negedge clk);
        check(sdo, 3'b000, "R1 mid-stream held");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule